// File: doc/BRIEF.md
# I2C Slave Address Status Monitor

This block watches an I2C bus from the slave side and keeps the status flags that firmware polls after each byte. It finds start and stop conditions on already-synchronized SCL and SDA. It counts SCL rising edges to frame each byte plus its acknowledge bit. It shifts in the first byte after every start, most significant bit first, and judges that byte against a programmable 7-bit own address and against the general-call address.

It keeps three flags and one pulse. The addressed flag has two setting rules, selected by a mode input, and only a data-buffer access clears it. The general-call flag is set by an all-zero first byte, and only bus start and stop events clear it. The last-bit flag follows SDA at each SCL rising edge. A one-cycle byte-complete pulse marks the end of each nine-bit frame. The block never drives the bus.

Top module: `i2c_slave_status_mon`

## Requirements
- R1: After reset, `addressed`, `gen_call`, `last_bit` and `byte_irq` are all 0.
- R2: A start is SDA going 1 to 0 while SCL stays 1. A stop is SDA going 0 to 1 while SCL stays 1. With `free_mode`=0, the first byte after a start is shifted in MSB first. If its bits 7:1 equal `own_addr`, `addressed` becomes 1 on the cycle after the eighth SCL rising edge, whatever the value of bit 0 (the read/write bit).
- R3: With `free_mode`=0, a first byte of 8'h00 also sets `addressed`. A first byte that is non-zero and whose bits 7:1 differ from `own_addr` leaves `addressed` at 0.
- R4: With `free_mode`=1, `addressed` becomes 1 after the eighth SCL rising edge of the first byte after a start, whatever that byte holds.
- R5: A one-cycle `buf_access` pulse clears `addressed`. Without such a pulse `addressed` stays 1 through stop conditions. Later bytes of the same transfer never set it.
- R6: `gen_call` becomes 1 after the eighth SCL rising edge when the first byte after a start is 8'h00, in either mode. A non-zero first byte, or any zero byte that is not the first byte, leaves it unchanged.
- R7: `gen_call` is cleared on the cycle after a start or stop condition is seen. `buf_access` does not clear it.
- R8: `last_bit` holds the SDA level sampled at the latest SCL rising edge. After the ninth rising edge of a frame it therefore holds the acknowledge bit.
- R9: `byte_irq` is a single-cycle pulse, issued once per frame, on the cycle after the ninth SCL rising edge.
- R10: A start seen in the middle of a byte, with no stop before it, resets the bit count and makes the next byte the first byte again, so that byte is judged as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronized SCL level |
| sda | input | 1 | Synchronized SDA level |
| own_addr | input | 7 | Programmed own slave address |
| free_mode | input | 1 | 1 = free data format (no address recognition), 0 = address recognition |
| buf_access | input | 1 | One-cycle pulse for each data-buffer read or write |
| addressed | output | 1 | Addressed-as-slave flag |
| gen_call | output | 1 | General-call flag |
| last_bit | output | 1 | SDA level at the last SCL rising edge |
| byte_irq | output | 1 | Byte-complete pulse after the ninth SCL rising edge |

## Verification
The assertions assume that `scl` and `sda` are already synchronous to `clk`, with each level held for several cycles. They also assume that SDA never changes in the same cycle that SCL rises, so a start or stop is never mistaken for a clock edge. The bench drives both lines only at falling clock edges. It holds every bus phase for at least two cycles, and it changes SDA only while SCL is low, except where it forms a start or stop on purpose. `buf_access` is given as a single-cycle pulse between frames. `own_addr` and `free_mode` are changed only while the bus is idle.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef logic [BYTE_W-1:0] rx_byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Address field is the upper bits; bit 0 carries direction.
  function automatic logic own_match(input rx_byte_t b, input addr_t a);
    return b[BYTE_W-1:1] == a;
  endfunction

  function automatic logic all_zero(input rx_byte_t b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_evt = scl && scl_q && sda_q && !sda;
  assign stop_evt  = scl && scl_q && !sda_q && sda;
  assign scl_rise  = scl && !scl_q;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              sda,
  output logic              byte_done,
  output logic              ack_done,
  output logic              first_byte,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST_DATA = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_SLOT  = CW'(BYTE_W);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-2:0] shreg;

  assign byte_done = scl_rise && (cnt == LAST_DATA);
  assign ack_done  = scl_rise && (cnt == ACK_SLOT);
  assign rx_byte   = {shreg, sda};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      first_byte <= 1'b0;
    end else if (start_evt) begin
      cnt        <= '0;
      first_byte <= 1'b1;
    end else if (stop_evt) begin
      cnt        <= '0;
      first_byte <= 1'b0;
    end else if (scl_rise) begin
      if (cnt == ACK_SLOT) begin
        cnt        <= '0;
        first_byte <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt < LAST_DATA) shreg <= {shreg[BYTE_W-3:0], sda};
      end
    end
  end

  // R9: frame counter never passes the acknowledge slot
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ACK_SLOT);
  // R10: any start, repeated or not, re-arms address detection
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0) && first_byte);
endmodule

// File: rtl/i2c_slave_status_mon.sv
module i2c_slave_status_mon
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              free_mode,
  input  logic              buf_access,
  output logic              addressed,
  output logic              gen_call,
  output logic              last_bit,
  output logic              byte_irq
);
  logic start_evt, stop_evt, scl_rise;
  logic byte_done, ack_done, first_byte;
  rx_byte_t rx_byte;
  logic addr_set, gc_set;

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise)
  );

  i2c_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .sda(sda), .byte_done(byte_done),
    .ack_done(ack_done), .first_byte(first_byte), .rx_byte(rx_byte)
  );

  assign gc_set   = byte_done && first_byte && all_zero(rx_byte);
  assign addr_set = byte_done && first_byte &&
                    (free_mode || own_match(rx_byte, own_addr) || all_zero(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      gen_call  <= 1'b0;
      last_bit  <= 1'b0;
      byte_irq  <= 1'b0;
    end else begin
      if (addr_set)        addressed <= 1'b1;
      else if (buf_access) addressed <= 1'b0;
      if (start_evt || stop_evt) gen_call <= 1'b0;
      else if (gc_set)           gen_call <= 1'b1;
      if (scl_rise) last_bit <= sda;
      byte_irq <= ack_done;
    end
  end

  // R7: a bus start or stop leaves the general-call flag low
  assert_gc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !gen_call);
  // R5: only a buffer access may drop the address flag
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addressed) |-> $past(buf_access));
  // R3: a general call always counts as being addressed
  assert_gc_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> addressed);
  // R9: byte-complete is never wider than one cycle
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq);
  // R8: last bit moves only at an SCL rising edge
  assert_lrb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise |=> $stable(last_bit));
endmodule

// File: tb/test_i2c_slave_status_mon.sv
module test_i2c_slave_status_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [6:0] own_addr = 7'h2B;
  logic free_mode = 1'b0, buf_access = 1'b0;
  logic addressed, gen_call, last_bit, byte_irq;
  int checks = 0, failures = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_slave_status_mon i_i2c_slave_status_mon (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .own_addr(own_addr),
    .free_mode(free_mode), .buf_access(buf_access), .addressed(addressed),
    .gen_call(gen_call), .last_bit(last_bit), .byte_irq(byte_irq)
  );

  always @(posedge clk) if (byte_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;  // from idle or from SCL low
    sda = 1'b1; wt(2); scl = 1'b1; wt(3); sda = 1'b0; wt(3); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop;
    sda = 1'b0; wt(2); scl = 1'b1; wt(3); sda = 1'b1; wt(3);
  endtask

  task automatic send_bit(input logic b);
    sda = b; wt(2); scl = 1'b1; wt(3); scl = 1'b0; wt(2);
  endtask

  task automatic send_frame(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  task automatic pulse_access;
    buf_access = 1'b1; wt(1); buf_access = 1'b0; wt(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wt(3);
    chk("R1 addressed", addressed, 0);
    chk("R1 gen_call", gen_call, 0);
    chk("R1 last_bit", last_bit, 0);
    chk("R1 byte_irq", byte_irq, 0);
    rst_n = 1'b1; wt(3);

    // Address-recognition sweep over every first byte
    for (int b = 0; b < 256; b++) begin
      logic ack;
      bit exp_a, exp_g;
      ack   = b[0] ^ b[3];
      exp_a = ((b >> 1) == own_addr) || (b == 0);
      exp_g = (b == 0);
      bus_start;
      irq_cnt = 0;
      send_frame(8'(b), ack);
      chk(exp_g ? "R3 gc addressed" : "R2 addressed", addressed, exp_a);
      chk("R6 gen_call", gen_call, exp_g);
      chk("R8 last_bit ack", last_bit, ack);
      chk("R9 irq count", irq_cnt, 1);
      pulse_access;
      chk("R5 cleared by access", addressed, 0);
      chk("R7 gc survives access", gen_call, exp_g);
      send_frame(8'h00, 1'b0);
      chk("R6 later zero byte", gen_call, exp_g);
      chk("R5 later byte no set", addressed, 0);
      bus_stop;
      chk("R7 gc cleared by stop", gen_call, 0);
    end

    // R5: flag persists over stop without access
    bus_start; send_frame({own_addr, 1'b1}, 1'b0); bus_stop;
    chk("R5 held over stop", addressed, 1);
    pulse_access;
    chk("R5 access clear", addressed, 0);

    // R7: start clears general call
    bus_start; send_frame(8'h00, 1'b0);
    chk("R7 gc set", gen_call, 1);
    bus_start;
    chk("R7 gc cleared by start", gen_call, 0);
    bus_stop; pulse_access;

    // R10: repeated start in mid-byte
    bus_start;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start;
    irq_cnt = 0;
    send_frame({own_addr, 1'b0}, 1'b1);
    chk("R10 restart address", addressed, 1);
    chk("R10 irq once", irq_cnt, 1);
    bus_stop; pulse_access;

    // Free-data-format sweep
    free_mode = 1'b1; wt(2);
    for (int b = 0; b < 256; b += 17) begin
      bus_start;
      send_frame(8'(b), 1'b1);
      chk("R4 free addressed", addressed, 1);
      chk("R6 free gen_call", gen_call, (b == 0) ? 1 : 0);
      pulse_access;
      bus_stop;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule